// File: doc/BRIEF.md
# Four-Operation Arithmetic Unit with Stored Status

This block is the arithmetic stage of a small datapath. It takes two 8-bit operands and four one-hot operation selects (add, increment, negate, subtract). It returns a wrapped 8-bit result together with live zero and negative indications. All arithmetic is two's complement and wraps modulo 256. Increment and negate use operand A only. Subtract forms B minus A.

A two-bit status register keeps the negative and zero indications of the last valid operation. A valid operation is a cycle in which exactly one select is high. In every other cycle the register keeps its value. When several selects are high at once, the cycle is treated as invalid. When no select is high, the cycle is treated as idle. In both cases the result is driven to zero.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the stored status stays cleared for two clock edges after `rst_n` rises.

Top module: `arith4_unit`

## Requirements
- R1: With only `do_add` high, `sum_out` equals (`a_in` + `b_in`) mod 256.
- R2: With only `do_inc` high, `sum_out` equals (`a_in` + 1) mod 256, whatever `b_in` holds.
- R3: With only `do_neg` high, `sum_out` equals (256 − `a_in`) mod 256, whatever `b_in` holds.
- R4: With only `do_sub` high, `sum_out` equals (`b_in` − `a_in`) mod 256.
- R5: `zero_now` is 1 exactly when `sum_out` is 0.
- R6: `neg_now` equals bit 7 of `sum_out`.
- R7: On a rising clock edge with exactly one select high, `neg_flag` and `zero_flag` take the `neg_now` and `zero_now` values of that cycle.
- R8: With no select high, `sum_out` is 0 and the stored flags keep their values across the edge.
- R9: With two or more selects high, `sum_out` is 0 and the stored flags keep their values across the edge.
- R10: While `rst_n` is low both stored flags read 0. They stay 0 until the second rising edge after `rst_n` returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| do_add | input | 1 | Select A + B |
| do_inc | input | 1 | Select A + 1 |
| do_neg | input | 1 | Select −A |
| do_sub | input | 1 | Select B − A |
| sum_out | output | 8 | Combinational result |
| zero_now | output | 1 | Result is zero (combinational) |
| neg_now | output | 1 | Result bit 7 (combinational) |
| zero_flag | output | 1 | Stored zero flag |
| neg_flag | output | 1 | Stored negative flag |

## Verification
The bench targets the wrap points, each chosen because a specific defect shows up there:
- 0x80 + 0x80 and increment of 0xFF must give zero with the zero flag set; an adder that leaked a carry would give a non-zero result instead.
- Negate of 0x80 must return 0x80 with the sign set.
- Negate of 0 must return 0.
- 0 − 1 must give 0xFF; swapping the subtract operands would give 1 instead of 0xFF.

Cycles with several selects high, and cycles with no select high, come straight after flag-setting operations. A register that loaded on any select, rather than only on exactly one, would overwrite the stored flags with the values of the forced-zero result.

A reset in the middle of the run checks that the flags clear and stay clear through the release delay.

// File: rtl/arith4_pkg.sv
`timescale 1ns/1ps
package arith4_pkg;

  typedef struct packed {
    logic add;
    logic inc;
    logic neg;
    logic sub;
  } op_sel_t;

  localparam int unsigned NUM_OPS = 4;

  function automatic logic exactly_one(input op_sel_t s);
    logic [2:0] cnt;
    cnt = {2'b00, s.add} + {2'b00, s.inc} + {2'b00, s.neg} + {2'b00, s.sub};
    return (cnt == 3'd1);
  endfunction

endpackage

// File: rtl/arith4_rst_sync.sv
`timescale 1ns/1ps
module arith4_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  generate
    if (STAGES < 2) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= 1'b1;
      end
      assign rst_q_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign rst_q_n = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/arith4_decode.sv
`timescale 1ns/1ps
module arith4_decode
  import arith4_pkg::*;
(
  input  op_sel_t sel,
  output logic    valid,
  output logic    invert_a,
  output logic    pass_b,
  output logic    carry_in
);
  always_comb begin
    valid    = exactly_one(sel);
    // the shared adder computes x + y + cin
    invert_a = sel.neg | sel.sub;   // x = ~A for negate and subtract
    pass_b   = sel.add | sel.sub;   // y = B only for add and subtract
    carry_in = sel.inc | sel.neg | sel.sub;
  end
endmodule

// File: rtl/arith4_core.sv
`timescale 1ns/1ps
module arith4_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         valid,
  input  logic         invert_a,
  input  logic         pass_b,
  input  logic         carry_in,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);
  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic [W-1:0] sum;

  always_comb begin
    x_op    = invert_a ? ~a : a;
    y_op    = pass_b ? b : '0;
    sum     = x_op + y_op + {{(W-1){1'b0}}, carry_in};
    res     = valid ? sum : '0;
    is_zero = (res == '0);
    is_neg  = res[W-1];
  end
endmodule

// File: rtl/arith4_flags.sv
`timescale 1ns/1ps
module arith4_flags (
  input  logic clk,
  input  logic rst_q_n,
  input  logic load,
  input  logic n_in,
  input  logic z_in,
  output logic n_q,
  output logic z_q
);
  logic n_d;
  logic z_d;

  always_comb begin
    n_d = n_q;
    z_d = z_q;
    if (load) begin
      n_d = n_in;
      z_d = z_in;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else begin
      n_q <= n_d;
      z_q <= z_d;
    end
  end
endmodule

// File: rtl/arith4_unit.sv
`timescale 1ns/1ps
module arith4_unit
  import arith4_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         do_add,
  input  logic         do_inc,
  input  logic         do_neg,
  input  logic         do_sub,
  output logic [W-1:0] sum_out,
  output logic         zero_now,
  output logic         neg_now,
  output logic         zero_flag,
  output logic         neg_flag
);
  op_sel_t sel_vec;
  logic    rst_q_n;
  logic    valid;
  logic    invert_a;
  logic    pass_b;
  logic    carry_in;

  assign sel_vec = '{add: do_add, inc: do_inc, neg: do_neg, sub: do_sub};

  arith4_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  arith4_decode u_dec (
    .sel      (sel_vec),
    .valid    (valid),
    .invert_a (invert_a),
    .pass_b   (pass_b),
    .carry_in (carry_in)
  );

  arith4_core #(.W(W)) u_core (
    .a        (a_in),
    .b        (b_in),
    .valid    (valid),
    .invert_a (invert_a),
    .pass_b   (pass_b),
    .carry_in (carry_in),
    .res      (sum_out),
    .is_zero  (zero_now),
    .is_neg   (neg_now)
  );

  arith4_flags u_flags (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .load    (valid),
    .n_in    (neg_now),
    .z_in    (zero_now),
    .n_q     (neg_flag),
    .z_q     (zero_flag)
  );
endmodule

// File: rtl/arith4_unit_chk.sv
`timescale 1ns/1ps
module arith4_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic [3:0]   sel,
  input logic [W-1:0] sum_out,
  input logic         zero_now,
  input logic         neg_now,
  input logic         zero_flag,
  input logic         neg_flag
);
  logic armed;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  a_r5_zero_ind: assert property (@(posedge clk) disable iff (!rst_q_n)
    zero_now == (sum_out == '0));

  a_r6_sign_ind: assert property (@(posedge clk) disable iff (!rst_q_n)
    neg_now == sum_out[W-1]);

  a_r7_load_flags: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && $countones(sel) == 1) |=>
      (neg_flag == $past(neg_now) && zero_flag == $past(zero_now)));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && sel == 4'b0000) |=> ($stable(neg_flag) && $stable(zero_flag)));

  a_r9_hold_multi: assert property (@(posedge clk) disable iff (!rst_q_n)
    (armed && $countones(sel) > 1) |=> ($stable(neg_flag) && $stable(zero_flag)));

  a_r9_zero_multi: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($countones(sel) > 1) |-> (sum_out == '0));

  a_r10_reset_clear: assert property (@(posedge clk)
    (!rst_q_n) |-> (!neg_flag && !zero_flag));
endmodule

bind arith4_unit arith4_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .sel       ({do_add, do_inc, do_neg, do_sub}),
  .sum_out   (sum_out),
  .zero_now  (zero_now),
  .neg_now   (neg_now),
  .zero_flag (zero_flag),
  .neg_flag  (neg_flag)
);

// File: tb/arith4_unit_test.sv
`timescale 1ns/1ps
module arith4_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [7:0] a_in = 8'h00;
  logic [7:0] b_in = 8'h00;
  logic       do_add = 1'b0, do_inc = 1'b0, do_neg = 1'b0, do_sub = 1'b0;
  logic [7:0] sum_out;
  logic       zero_now, neg_now, zero_flag, neg_flag;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic exp_n = 1'b0;
  logic exp_z = 1'b0;

  always #2 clk = ~clk;

  arith4_unit uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .do_add(do_add), .do_inc(do_inc), .do_neg(do_neg), .do_sub(do_sub),
    .sum_out(sum_out), .zero_now(zero_now), .neg_now(neg_now),
    .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  // sel bit order: [3]=add [2]=inc [1]=neg [0]=sub
  function automatic logic [7:0] model_res(input logic [7:0] a, input logic [7:0] b,
                                           input logic [3:0] s);
    case (s)
      4'b1000: return a + b;
      4'b0100: return a + 8'd1;
      4'b0010: return 8'd0 - a;
      4'b0001: return b - a;
      default: return 8'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'b1000: return "R1";
      4'b0100: return "R2";
      4'b0010: return "R3";
      4'b0001: return "R4";
      4'b0000: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [3:0] s);
    logic [7:0] e;
    @(negedge clk);
    a_in = a; b_in = b;
    {do_add, do_inc, do_neg, do_sub} = s;
    e = model_res(a, b, s);
    #1;
    check(req_of(s), sum_out, e);
    check("R5", {7'd0, zero_now}, {7'd0, e == 8'd0});
    check("R6", {7'd0, neg_now}, {7'd0, e[7]});
    @(posedge clk);
    #1;
    if ($countones(s) == 1) begin
      exp_n = e[7];
      exp_z = (e == 8'd0);
    end
    check($countones(s) == 1 ? "R7" : req_of(s), {6'd0, neg_flag, zero_flag}, {6'd0, exp_n, exp_z});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {do_add, do_inc, do_neg, do_sub} = 4'b0000;
    #1;
    check("R10", {6'd0, neg_flag, zero_flag}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // flags load a valid op only after the synchronised release
    do_neg = 1'b1; a_in = 8'h01;
    @(posedge clk); #1;
    check("R10", {6'd0, neg_flag, zero_flag}, 8'd0);
    @(negedge clk);
    do_neg = 1'b0;
    repeat (3) @(negedge clk);
    exp_n = 1'b0; exp_z = 1'b0;
    check("R10", {6'd0, neg_flag, zero_flag}, 8'd0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10", {6'd0, neg_flag, zero_flag}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run_op(8'h80, 8'h80, 4'b1000); // R1 wrap to zero
    run_op(8'h7F, 8'h01, 4'b1000); // R1 into sign
    run_op(8'hFF, 8'h55, 4'b0100); // R2 wrap, B ignored
    run_op(8'h80, 8'hAA, 4'b0010); // R3 -0x80 = 0x80
    run_op(8'h00, 8'h33, 4'b0010); // R3 -0 = 0
    run_op(8'h01, 8'h00, 4'b0001); // R4 0-1 = FF
    run_op(8'h5A, 8'h5A, 4'b0001); // R4 equal -> zero
    run_op(8'h10, 8'h20, 4'b1100); // R9 multi select holds Z=1
    run_op(8'h01, 8'h00, 4'b0001); // set N
    run_op(8'h00, 8'h00, 4'b1111); // R9 all selects
    run_op(8'h00, 8'h00, 4'b0000); // R8 idle
    run_op(8'h03, 8'h09, 4'b0011); // R9

    do_reset();
    run_op(8'h02, 8'h07, 4'b0001);

    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] s;
      int pick;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: s = 4'b1000;
        1: s = 4'b0100;
        2: s = 4'b0010;
        3: s = 4'b0001;
        4: s = 4'b1000;
        5: s = 4'b0001;
        6: s = 4'b0000;
        default: s = 4'($urandom);
      endcase
      run_op(8'($urandom), 8'($urandom), s);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule